// File: doc/BRIEF.md
# Logic-in-Memory Word Array

This block is a word-addressed store whose words each carry a small persistent tag naming a bitwise function. A word whose tag is NONE is plain storage. Once a run of words has been tagged with a function, a store to such a word no longer overwrites it. The incoming data is merged into the old contents with the tagged function, and the result lands back in the same word. The memory thus acts as an in-place bitwise processor without moving data out to a processor.

Requests arrive on one valid/ready port. Each request carries a command, an address, a length, an immediate offset, a function code and write data. There are four commands. A plain load returns the raw word. A store either writes plainly or performs the read-modify-write. A range activation tags consecutive words, one per cycle. A masked load returns a word merged with a mask operand. Loads answer on a registered response port. Rejected requests raise a one-cycle error pulse, and a clipped activation raises a one-cycle wrap pulse.

Top module: `lim_array`

## Requirements
- R1: After a synchronous reset every tag is NONE. The port is ready, and the response, error and wrap outputs are low.
- R2: A plain load (cmd 0) accepted on edge k drives rsp_valid high with the raw stored word, whatever its tag, during the cycle after edge k.
- R3: An activation (cmd 2) with length n>0 and function code op writes one tag per cycle, to req_addr, req_addr+1, and so on, on edges k+1..k+n. req_ready is low from edge k until edge k+n. The codes are NONE=0, AND=1, OR=2, XOR=3, NAND=4, NOR=5, XNOR=6.
- R4: A store (cmd 1) to a word whose tag is not NONE writes old-op-data to that word on edge k+1. req_ready is low for that one cycle. For example, OR over words 0x08..0x0A followed by a store of D to 0x08 leaves old|D.
- R5: Such a logic store is rejected unless its immediate is zero and its address equals the base of the most recent accepted activation. A rejected store pulses err_flag in the cycle after acceptance and leaves memory unchanged.
- R6: A masked load (cmd 3) returns word-op-mask, with op from req_op and the mask from req_wdata, one cycle after acceptance. Memory is unchanged. Op NONE returns the raw word.
- R7: Code 7 is reserved. An activation or masked load that uses it pulses err_flag and changes no tag. It gives no response and does not update the stored base.
- R8: An activation that would run past the last word is clipped at the top address and pulses wrap_flag in the cycle after acceptance. Tags near address 0 are untouched.
- R9: An activation of length zero keeps req_ready high and changes no tag, but it does record its base.
- R10: Activating a range with NONE makes its words plain storage again.
- R11: A store to a NONE word writes req_wdata to req_addr on the accepting edge. The immediate is ignored, and the port stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cmd | input | 2 | 0 load, 1 store, 2 activate, 3 masked load |
| req_addr | input | 8 | Word address or range base |
| req_len | input | 9 | Range length for activation |
| req_imm | input | 12 | Immediate offset of a store |
| req_op | input | 3 | Function code for activation or masked load |
| req_wdata | input | 32 | Store data or mask |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 32 | Load response data |
| err_flag | output | 1 | One-cycle pulse on a rejected request |
| wrap_flag | output | 1 | One-cycle pulse on a clipped activation |

## Verification
Load and masked-load results are due in the cycle after the accepting edge. The error and wrap pulses fall in that same cycle. A logic store's write lands one edge later, and an activation's tags land one per edge after acceptance. A behavioural reference model in the bench advances on each rising edge and predicts ready, response, error and wrap. The bench compares the ports against it on every falling edge, which is away from the edge at which any of them change. Directed checks with hand-computed values sample the response in the cycle right after acceptance.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic [2:0] {
    FN_NONE = 3'd0, FN_AND = 3'd1, FN_OR = 3'd2, FN_XOR = 3'd3,
    FN_NAND = 3'd4, FN_NOR = 3'd5, FN_XNOR = 3'd6, FN_RSVD = 3'd7
  } lim_fn_e;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0, CMD_STORE = 2'd1, CMD_ACT = 2'd2, CMD_MASK = 2'd3
  } lim_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_ACT = 2'd1, ST_WR = 2'd2
  } lim_state_e;
endpackage

// File: rtl/lim_bitop.sv
module lim_bitop #(
  parameter int W = 32
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import lim_pkg::*;
  always_comb begin
    case (lim_fn_e'(fn))
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_NAND: y = ~(a & b);
      FN_NOR:  y = ~(a | b);
      FN_XNOR: y = ~(a ^ b);
      default: y = a;
    endcase
  end
endmodule

// File: rtl/lim_tag_file.sv
module lim_tag_file #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [2:0]    wtag,
  input  logic [AW-1:0] raddr,
  output logic [2:0]    rtag
);
  logic [2:0] tags [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tags[i] <= 3'd0;
    end else if (we) begin
      tags[waddr] <= wtag;
    end
  end

  assign rtag = tags[raddr];

  // R3
  tag_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we)) |-> (waddr == $past(waddr) + 1'b1));
endmodule

// File: rtl/lim_data_ram.sv
module lim_data_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lim_array.sv
module lim_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int IMM_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_cmd,
  input  logic [$clog2(DEPTH)-1:0]  req_addr,
  input  logic [$clog2(DEPTH):0]    req_len,
  input  logic [IMM_W-1:0]          req_imm,
  input  logic [2:0]                req_op,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_data,
  output logic                      err_flag,
  output logic                      wrap_flag
);
  import lim_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = AW + 1;
  localparam int SUM_W = AW + 2;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  lim_state_e        state;
  logic [AW-1:0]     cur_addr, act_base, wr_addr_q;
  logic [LEN_W-1:0]  rem;
  logic [2:0]        act_fn, fn_q;
  logic [DATA_W-1:0] wd_q, rd_q, bit_y;
  logic              rsp_q, err_q, wrap_q;

  logic              accept, is_load, is_store, is_act, is_mask;
  logic [2:0]        tag_rd;
  logic              st_logic, st_ok, fn_rsvd;
  logic [SUM_W-1:0]  span_end;
  logic              over;
  logic [LEN_W-1:0]  clip_len;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_load   = (lim_cmd_e'(req_cmd) == CMD_LOAD);
  assign is_store  = (lim_cmd_e'(req_cmd) == CMD_STORE);
  assign is_act    = (lim_cmd_e'(req_cmd) == CMD_ACT);
  assign is_mask   = (lim_cmd_e'(req_cmd) == CMD_MASK);
  assign fn_rsvd   = (lim_fn_e'(req_op) == FN_RSVD);
  assign st_logic  = (tag_rd != 3'd0);
  assign st_ok     = (req_imm == '0) && (req_addr == act_base);
  assign span_end  = {2'b00, req_addr} + {1'b0, req_len};
  assign over      = span_end > DEPTH_S;
  assign clip_len  = over ? LEN_W'(DEPTH_S - {2'b00, req_addr}) : req_len;

  lim_tag_file #(.DEPTH(DEPTH), .AW(AW)) u_tags (
    .clk(clk), .rst(rst),
    .we(state == ST_ACT), .waddr(cur_addr), .wtag(act_fn),
    .raddr(req_addr), .rtag(tag_rd)
  );

  assign ram_we    = (accept && is_store && !st_logic) || (state == ST_WR);
  assign ram_waddr = (state == ST_WR) ? wr_addr_q : req_addr;
  assign ram_wdata = (state == ST_WR) ? bit_y : req_wdata;

  lim_data_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(accept), .raddr(req_addr), .rdata(rd_q)
  );

  lim_bitop #(.W(DATA_W)) u_bitop (
    .fn(fn_q), .a(rd_q), .b(wd_q), .y(bit_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      act_base  <= '0;
      wr_addr_q <= '0;
      rem       <= '0;
      act_fn    <= 3'd0;
      fn_q      <= 3'd0;
      wd_q      <= '0;
      rsp_q     <= 1'b0;
      err_q     <= 1'b0;
      wrap_q    <= 1'b0;
    end else begin
      rsp_q  <= 1'b0;
      err_q  <= 1'b0;
      wrap_q <= 1'b0;
      case (state)
        ST_ACT: begin
          cur_addr <= cur_addr + 1'b1;
          rem      <= rem - 1'b1;
          if (rem == LEN_W'(1)) state <= ST_IDLE;
        end
        ST_WR: state <= ST_IDLE;
        default: begin
          if (accept) begin
            wd_q <= req_wdata;
            if (is_load) begin
              fn_q  <= 3'd0;
              rsp_q <= 1'b1;
            end else if (is_mask) begin
              fn_q  <= req_op;
              rsp_q <= !fn_rsvd;
              err_q <= fn_rsvd;
            end else if (is_store) begin
              if (st_logic) begin
                if (st_ok) begin
                  fn_q      <= tag_rd;
                  wr_addr_q <= req_addr;
                  state     <= ST_WR;
                end else begin
                  err_q <= 1'b1;
                end
              end
            end else if (fn_rsvd) begin
              err_q <= 1'b1;
            end else begin
              act_base <= req_addr;
              cur_addr <= req_addr;
              act_fn   <= req_op;
              rem      <= clip_len;
              wrap_q   <= over;
              if (clip_len != '0) state <= ST_ACT;
            end
          end
        end
      endcase
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = bit_y;
  assign err_flag  = err_q;
  assign wrap_flag = wrap_q;

  // R4
  logic_store_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_store && st_logic && st_ok) |=> !req_ready);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready && (is_load || is_mask)));
  // R7
  err_excl_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && err_flag));
  // R5
  reject_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !$past(ram_we));
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_act && !fn_rsvd && req_len == '0) |=> req_ready);
endmodule

// File: tb/lim_array_bench.sv
module lim_array_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cmd = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [8:0]  req_len = 9'd0;
  logic [11:0] req_imm = 12'd0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        err_flag;
  logic        wrap_flag;

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  lim_array u_lim_array (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .req_imm(req_imm), .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .err_flag(err_flag), .wrap_flag(wrap_flag)
  );

  // Reference model state
  logic [31:0] m_mem [256];
  int          m_tag [256];
  int          busy = 0, cur = 0, a_op = 0, act_base = 0;
  bit          pend = 0;
  int          p_a = 0, p_tag = 0;
  logic [31:0] p_d = 0;
  bit          e_ready = 1, e_valid = 0, e_err = 0, e_wrap = 0;
  logic [31:0] e_data = 0;

  function automatic logic [31:0] mf(int fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return ~(a & b);
      5: return ~(a | b);
      6: return ~(a ^ b);
      default: return a;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) m_tag[i] = 0;
      busy = 0; pend = 0; act_base = 0;
      e_ready = 1; e_valid = 0; e_err = 0; e_wrap = 0;
    end else begin
      bit acc;
      int a, n;
      acc = req_valid && e_ready;
      e_valid = 0; e_err = 0; e_wrap = 0;
      a = int'(req_addr);
      if (pend) begin
        m_mem[p_a] = mf(p_tag, m_mem[p_a], p_d);
        pend = 0;
      end else if (busy > 0) begin
        m_tag[cur] = a_op;
        cur++;
        busy--;
      end else if (acc) begin
        case (req_cmd)
          2'd0: begin e_valid = 1; e_data = m_mem[a]; end
          2'd1: begin
            if (m_tag[a] == 0) m_mem[a] = req_wdata;
            else if (req_imm != 0 || a != act_base) e_err = 1;
            else begin pend = 1; p_a = a; p_d = req_wdata; p_tag = m_tag[a]; end
          end
          2'd2: begin
            if (req_op == 3'd7) e_err = 1;
            else begin
              act_base = a;
              n = int'(req_len);
              if (a + n > 256) begin n = 256 - a; e_wrap = 1; end
              busy = n; cur = a; a_op = int'(req_op);
            end
          end
          default: begin
            if (req_op == 3'd7) e_err = 1;
            else begin e_valid = 1; e_data = mf(int'(req_op), m_mem[a], req_wdata); end
          end
        endcase
      end
      e_ready = (busy == 0) && !pend;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(req_ready === e_ready, cur_req, 32'(req_ready), 32'(e_ready), "ready");
      chk(rsp_valid === e_valid, cur_req, 32'(rsp_valid), 32'(e_valid), "rsp_valid");
      chk(err_flag === e_err, cur_req, 32'(err_flag), 32'(e_err), "err_flag");
      chk(wrap_flag === e_wrap, cur_req, 32'(wrap_flag), 32'(e_wrap), "wrap_flag");
      if (e_valid) chk(rsp_data === e_data, cur_req, rsp_data, e_data, "rsp_data");
    end
  end

  task automatic send(logic [1:0] cmd, logic [7:0] addr, logic [8:0] len,
                      logic [11:0] imm, logic [2:0] op, logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = len;
    req_imm = imm; req_op = op; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_load(logic [7:0] addr, logic [31:0] exp, string req);
    send(2'd0, addr, 9'd0, 12'd0, 3'd0, 32'd0);
    chk(rsp_valid === 1'b1 && rsp_data === exp, req, rsp_data, exp, "direct load");
  endtask

  task automatic expect_mask(logic [7:0] addr, logic [2:0] op, logic [31:0] m,
                             logic [31:0] exp, string req);
    send(2'd3, addr, 9'd0, 12'd0, op, m);
    chk(rsp_valid === 1'b1 && rsp_data === exp, req, rsp_data, exp, "direct mask");
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && err_flag === 1'b0 && wrap_flag === 1'b0,
        "R1", {28'd0, req_ready, rsp_valid, err_flag, wrap_flag}, 32'h8, "reset state");
    chk_on = 1'b1;

    cur_req = "R11";
    send(2'd1, 8'h10, 9'd0, 12'd5, 3'd0, 32'hCAFE_0001);
    expect_load(8'h10, 32'hCAFE_0001, "R11");
    send(2'd1, 8'h08, 9'd0, 12'd0, 3'd0, 32'h0F0F_0000);
    send(2'd1, 8'h09, 9'd0, 12'd0, 3'd0, 32'h1234_5678);
    send(2'd1, 8'h0A, 9'd0, 12'd0, 3'd0, 32'hFFFF_0000);
    send(2'd1, 8'h0B, 9'd0, 12'd0, 3'd0, 32'hA5A5_A5A5);
    send(2'd1, 8'hFE, 9'd0, 12'd0, 3'd0, 32'h0000_FFFF);
    send(2'd1, 8'hFF, 9'd0, 12'd0, 3'd0, 32'h1111_1111);
    send(2'd1, 8'h00, 9'd0, 12'd0, 3'd0, 32'h2222_2222);
    send(2'd1, 8'h14, 9'd0, 12'd0, 3'd0, 32'h00FF_00FF);

    cur_req = "R3";
    send(2'd2, 8'h08, 9'd3, 12'd0, 3'd2, 32'd0);
    cur_req = "R4";
    send(2'd1, 8'h08, 9'd0, 12'd0, 3'd0, 32'h0000_00FF);
    expect_load(8'h08, 32'h0F0F_00FF, "R4");

    cur_req = "R5";
    send(2'd1, 8'h09, 9'd0, 12'd0, 3'd0, 32'hFFFF_FFFF);
    send(2'd1, 8'h08, 9'd0, 12'd1, 3'd0, 32'hFFFF_FFFF);
    expect_load(8'h09, 32'h1234_5678, "R5");
    expect_load(8'h08, 32'h0F0F_00FF, "R5");
    send(2'd1, 8'h0B, 9'd0, 12'd0, 3'd0, 32'h5A5A_5A5A);
    expect_load(8'h0B, 32'h5A5A_5A5A, "R3");

    cur_req = "R2";
    expect_load(8'h0A, 32'hFFFF_0000, "R2");

    cur_req = "R6";
    for (int op = 0; op < 7; op++) begin
      send(2'd3, 8'h09, 9'd0, 12'd0, 3'(op), 32'h00FF_F0F0);
    end
    expect_mask(8'h09, 3'd1, 32'hFF00_FF00, 32'h1200_5600, "R6");
    expect_mask(8'h09, 3'd6, 32'h0000_0000, 32'hEDCB_A987, "R6");
    expect_load(8'h09, 32'h1234_5678, "R6");

    cur_req = "R7";
    send(2'd2, 8'h30, 9'd4, 12'd0, 3'd7, 32'd0);
    send(2'd3, 8'h09, 9'd0, 12'd0, 3'd7, 32'd0);
    send(2'd1, 8'h08, 9'd0, 12'd0, 3'd0, 32'h0000_0F00);
    expect_load(8'h08, 32'h0F0F_0FFF, "R7");

    cur_req = "R8";
    send(2'd2, 8'hFE, 9'd5, 12'd0, 3'd3, 32'd0);
    send(2'd1, 8'hFE, 9'd0, 12'd0, 3'd0, 32'h0000_0F0F);
    expect_load(8'hFE, 32'h0000_F0F0, "R8");
    send(2'd1, 8'hFF, 9'd0, 12'd0, 3'd0, 32'h3333_3333);
    expect_load(8'hFF, 32'h1111_1111, "R8");
    send(2'd1, 8'h00, 9'd0, 12'd0, 3'd0, 32'h4444_4444);
    expect_load(8'h00, 32'h4444_4444, "R8");

    cur_req = "R9";
    send(2'd2, 8'h0B, 9'd0, 12'd0, 3'd1, 32'd0);
    send(2'd1, 8'h0B, 9'd0, 12'd0, 3'd0, 32'h7777_7777);
    expect_load(8'h0B, 32'h7777_7777, "R9");

    cur_req = "R10";
    send(2'd2, 8'h08, 9'd3, 12'd0, 3'd0, 32'd0);
    send(2'd1, 8'h09, 9'd0, 12'd0, 3'd0, 32'h9999_0000);
    expect_load(8'h09, 32'h9999_0000, "R10");

    cur_req = "R4";
    for (int op = 1; op < 7; op++) begin
      send(2'd2, 8'h14, 9'd1, 12'd0, 3'(op), 32'd0);
      send(2'd1, 8'h14, 9'd0, 12'd0, 3'd0, 32'h0F0F_3C3C);
      send(2'd0, 8'h14, 9'd0, 12'd0, 3'd0, 32'd0);
    end
    send(2'd2, 8'h14, 9'd1, 12'd0, 3'd2, 32'd0);
    send(2'd2, 8'h14, 9'd1, 12'd0, 3'd0, 32'd0);
    send(2'd1, 8'h14, 9'd0, 12'd0, 3'd0, 32'h0000_0000);
    expect_load(8'h14, 32'h0000_0000, "R10");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule